// File: doc/BRIEF.md
# Third-Order Single-Loop Delta-Sigma Modulus Sequencer

This block turns a fixed fractional word into a stream of small signed integers whose long-run average equals that word. A fractional-N divider adds each integer to its integer modulus, once per reference cycle, so that the average division ratio carries the fractional part. The loop is a single third-order chain of three cascaded integrators. The quantized output is subtracted at the head of the chain. The three integrator states are combined with the weights 2, 1.5 and 0.5 into one summing node, and a multi-bit quantizer reads that node.

The word has 20 bits of fraction and is read as a value in [0, 1). The integrators hold 24-bit two's-complement states on the same scale, and the summing node is 26 bits wide. The weights are built from shifts and adds only. The quantizer takes the floor of the node, clips it to a signed 3-bit range, and the output is registered together with a valid strobe. When the enable is low the loop is frozen.

Top module: `ciff3_dsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three integrators clear to zero and the block shows `mod_out` = 0 and `mod_valid` = 0 after that edge.
- R2: A rising edge with `en` high advances the loop by one step, and the new sample appears on `mod_out` with `mod_valid` = 1 after that same edge. A rising edge with `en` low leaves the integrators and `mod_out` unchanged and drives `mod_valid` to 0. A sequence that is interrupted by idle cycles therefore resumes exactly where it stopped.
- R3: When the word is 0, every output sample is 0.
- R4: The summing node weights the first, second and third integrators by 2, 1.5 and 0.5. The quantized output is fed back at the first integrator, scaled by 2^20. Starting from reset with the word 0xC0000 (0.75), the first four samples are 0, 1, 2, 0.
- R5: The quantizer takes the floor of the summing node, not the rounded value. Starting from reset with the word 0x40000 (0.25), the first four samples are 0, 0, 1, 0.
- R6: `mod_out` is signed 3-bit two's complement. After N enabled steps from reset with a constant word W, the quantity |sum(mod_out)·2^20 − N·W| stays below 2^23. This means the mean output tracks W/2^20.
- R7: For any constant word, the second and third integrators never wrap around their 24-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the loop by one step on this edge |
| frac_word | input | 20 | Unsigned fraction, value frac_word / 2^20 |
| mod_out | output | 3 | Signed modulus offset, two's complement, -4..+3 |
| mod_valid | output | 1 | High for one cycle after each enabled step |

## Verification
Each enabled rising edge yields its sample at the outputs right after that edge, so a sample is due one edge after the enable is seen. The bench drives inputs just after a falling edge and reads outputs at the following falling edge. A sample whose step was enabled in one half-period is compared in the next, and a driver task places its expected value in the scoreboard queue before that edge. The idle and reset checks are made one full edge after `en` or `rst_n` changes. The long-run mean checks take the sample total only after one extra idle edge, so that the last enabled step is included.

// File: rtl/ciff3_dsm_pkg.sv
// Package: shared defaults and helpers for the third-order modulator.
// Assumes: values are two's complement, scaled by 2**FRAC_W.
package ciff3_dsm_pkg;

    localparam int DEF_FRAC_W = 20;   // fraction bits of the input word
    localparam int DEF_ACC_W  = 24;   // integrator state width
    localparam int DEF_SUM_W  = 26;   // summing node width
    localparam int DEF_Q_W    = 3;    // quantizer output width
    localparam int N_STAGES   = 3;    // loop order

    // Lowest level a signed width-w value can take.
    function automatic int lvl_min(input int w);
        return -(1 << (w - 1));
    endfunction

    // Highest level a signed width-w value can take.
    function automatic int lvl_max(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

endpackage

// File: rtl/ciff3_integ.sv
// Module: one delaying integrator stage of the loop.
// Does: adds its increment to the stored state on every enabled edge.
// Assumes: the caller sizes W so that the state never wraps.
module ciff3_integ #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] inc,
    output logic signed [W-1:0] state
);

    // Accumulate on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (en) begin
            state <= state + inc;
        end
    end

endmodule

// File: rtl/ciff3_ffsum.sv
// Module: distributed feedforward summing node.
// Does: node = 2*s1 + 1.5*s2 + 0.5*s3, using shifts and adds only.
// Assumes: SUM_W >= ACC_W + 2; halving floors toward minus infinity.
module ciff3_ffsum #(
    parameter int ACC_W = 24,
    parameter int SUM_W = 26
) (
    input  logic signed [ACC_W-1:0] s1,
    input  logic signed [ACC_W-1:0] s2,
    input  logic signed [ACC_W-1:0] s3,
    output logic signed [SUM_W-1:0] node
);

    localparam int EXT_W = SUM_W - ACC_W;

    logic signed [SUM_W-1:0] e1, e2, e3;
    logic signed [SUM_W-1:0] w1, w2, w3;

    // Sign-extend the integrator states to the node width.
    always_comb begin
        e1 = {{EXT_W{s1[ACC_W-1]}}, s1};
        e2 = {{EXT_W{s2[ACC_W-1]}}, s2};
        e3 = {{EXT_W{s3[ACC_W-1]}}, s3};
    end

    // Apply the weights: doubling, one and a half, and halving.
    always_comb begin
        w1 = e1 <<< 1;
        w2 = e2 + (e2 >>> 1);
        w3 = e3 >>> 1;
    end

    // Sum the weighted terms.
    always_comb begin
        node = w1 + w2 + w3;
    end

endmodule

// File: rtl/ciff3_quant.sv
// Module: multi-bit quantizer with feedback scaling.
// Does: floors the node to an integer, clips it to Q_W signed bits,
//       and returns the level rescaled to the integrator scale.
// Assumes: ACC_W > Q_W + FRAC_W and SUM_W > FRAC_W.
module ciff3_quant
    import ciff3_dsm_pkg::*;
#(
    parameter int FRAC_W = 20,
    parameter int ACC_W  = 24,
    parameter int SUM_W  = 26,
    parameter int Q_W    = 3
) (
    input  logic signed [SUM_W-1:0] node,
    output logic signed [Q_W-1:0]   level,
    output logic signed [ACC_W-1:0] fb
);

    localparam int FB_EXT = ACC_W - Q_W - FRAC_W;
    localparam logic signed [SUM_W-1:0] LO = SUM_W'(lvl_min(Q_W));
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(lvl_max(Q_W));

    logic signed [SUM_W-1:0] ipart;

    // Floor: an arithmetic shift drops the fraction toward minus infinity.
    always_comb begin
        ipart = node >>> FRAC_W;
    end

    // Clip to the signed output range.
    always_comb begin
        if (ipart < LO) begin
            level = LO[Q_W-1:0];
        end else if (ipart > HI) begin
            level = HI[Q_W-1:0];
        end else begin
            level = ipart[Q_W-1:0];
        end
    end

    // Return the level on the integrator scale for the feedback path.
    always_comb begin
        fb = {{FB_EXT{level[Q_W-1]}}, level, {FRAC_W{1'b0}}};
    end

endmodule

// File: rtl/ciff3_dsm.sv
// Module: third-order single-loop delta-sigma modulator (top).
// Does: one step per enabled reference edge. The first integrator takes
//       input minus feedback, and each later one integrates its predecessor.
//       The weighted states are quantized and the result is registered.
// Assumes: frac_word is an unsigned fraction; synchronous active-low reset.
module ciff3_dsm
    import ciff3_dsm_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int SUM_W  = DEF_SUM_W,
    parameter int Q_W    = DEF_Q_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [FRAC_W-1:0]       frac_word,
    output logic signed [Q_W-1:0]   mod_out,
    output logic                    mod_valid
);

    localparam int IN_EXT = ACC_W - FRAC_W;

    logic signed [ACC_W-1:0] stage_q  [N_STAGES];
    logic signed [ACC_W-1:0] stage_in [N_STAGES];
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] word_ext;
    logic signed [SUM_W-1:0] node;
    logic signed [Q_W-1:0]   level;

    // Zero-extend the unsigned fraction onto the signed integrator scale.
    always_comb begin
        word_ext = {{IN_EXT{1'b0}}, frac_word};
    end

    // Build the integrator chain; the head stage subtracts the feedback.
    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stage_in[k] = word_ext - fb;
        end else begin : g_tail
            assign stage_in[k] = stage_q[k-1];
        end

        ciff3_integ #(.W(ACC_W)) u_integ (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .inc   (stage_in[k]),
            .state (stage_q[k])
        );
    end

    ciff3_ffsum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_ffsum (
        .s1   (stage_q[0]),
        .s2   (stage_q[1]),
        .s3   (stage_q[2]),
        .node (node)
    );

    ciff3_quant #(
        .FRAC_W (FRAC_W),
        .ACC_W  (ACC_W),
        .SUM_W  (SUM_W),
        .Q_W    (Q_W)
    ) u_quant (
        .node  (node),
        .level (level),
        .fb    (fb)
    );

    // Register the sample and strobe it once per enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_out   <= '0;
            mod_valid <= 1'b0;
        end else begin
            mod_valid <= en;
            if (en) begin
                mod_out <= level;
            end
        end
    end

endmodule

// File: rtl/ciff3_dsm_chk.sv
// Module: property checker bound to the modulator top.
// Does: watches reset, enable cadence, hold behaviour and integrator wrap.
// Assumes: bound into ciff3_dsm; sees the states of the tail integrators.
module ciff3_dsm_chk #(
    parameter int ACC_W = 24,
    parameter int Q_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic signed [Q_W-1:0]   mod_out,
    input logic                    mod_valid,
    input logic signed [ACC_W-1:0] s1,
    input logic signed [ACC_W-1:0] s2,
    input logic signed [ACC_W-1:0] s3
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!mod_valid && mod_out == '0));

    // R2
    valid_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> mod_valid);

    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mod_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(mod_out));

    // R7
    no_wrap_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2[ACC_W-1] == s1[ACC_W-1]) |=> s2[ACC_W-1] == $past(s2[ACC_W-1]));

    // R7
    no_wrap_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s3[ACC_W-1] == s2[ACC_W-1]) |=> s3[ACC_W-1] == $past(s3[ACC_W-1]));

endmodule

bind ciff3_dsm ciff3_dsm_chk #(.ACC_W(ACC_W), .Q_W(Q_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mod_out   (mod_out),
    .mod_valid (mod_valid),
    .s1        (stage_q[0]),
    .s2        (stage_q[1]),
    .s3        (stage_q[2])
);

// File: tb/tb_ciff3_dsm.sv
// Bench: scoreboard for the third-order modulator. Driver tasks queue the
// expected samples; a monitor at each falling edge pops and compares them.
module tb_ciff3_dsm;

    localparam int FRAC_W = 20;
    localparam int Q_W    = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  en = 1'b0;
    logic [FRAC_W-1:0]     frac_word = '0;
    logic signed [Q_W-1:0] mod_out;
    logic                  mod_valid;

    int     total = 0;
    int     bad = 0;
    int     exp_q[$];
    longint acc_sum = 0;
    longint acc_cnt = 0;
    bit     finished = 1'b0;

    always #2.5 clk = ~clk;

    ciff3_dsm dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .frac_word (frac_word),
        .mod_out   (mod_out),
        .mod_valid (mod_valid)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: accumulate valid samples and compare against the queue.
    always @(negedge clk) begin
        if (rst_n && mod_valid) begin
            acc_sum += longint'(mod_out);
            acc_cnt++;
            if (exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check(int'(mod_out) == e, "R3/R4/R5 sample", int'(mod_out), e);
            end
        end
    end

    // Reset for a few edges, then release; leaves time at negedge+1.
    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        en = 1'b0;
        repeat (3) begin @(negedge clk); #1; end
        rst_n = 1'b1;
    endtask

    // One enabled step with its expected sample pushed to the scoreboard.
    task automatic step(input logic [FRAC_W-1:0] w, input int e);
        en = 1'b1;
        frac_word = w;
        exp_q.push_back(e);
        @(negedge clk); #1;
        en = 1'b0;
    endtask

    // Long free run with a constant word, then the mean check.
    task automatic mean_run(input logic [FRAC_W-1:0] w, input int n);
        longint s0, c0, err, lim;
        do_reset();
        @(negedge clk); #1;
        s0 = acc_sum;
        c0 = acc_cnt;
        en = 1'b1;
        frac_word = w;
        repeat (n) begin @(negedge clk); #1; end
        en = 1'b0;
        @(negedge clk); #1;
        check(acc_cnt - c0 == longint'(n), "R2 step count", acc_cnt - c0, n);
        err = (acc_sum - s0) * (longint'(1) << FRAC_W) - longint'(n) * longint'(w);
        if (err < 0) err = -err;
        lim = longint'(1) << 23;
        check(err < lim, "R6 mean error", err, lim);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic signed [Q_W-1:0] held;

        // R1: reset state.
        do_reset();
        @(negedge clk); #1;
        check(mod_valid == 1'b0, "R1 valid after reset", mod_valid, 0);
        check(mod_out == '0, "R1 out after reset", mod_out, 0);

        // R3: zero word gives all-zero samples.
        for (int i = 0; i < 64; i++) step(20'h00000, 0);

        // R4: weights and feedback with 0.75, interrupted by idle cycles (R2).
        do_reset();
        @(negedge clk); #1;
        step(20'hC0000, 0);
        step(20'hC0000, 1);
        held = mod_out;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(mod_valid == 1'b0, "R2 idle valid", mod_valid, 0);
            check(mod_out == held, "R2 idle hold", mod_out, held);
        end
        step(20'hC0000, 2);
        step(20'hC0000, 0);

        // R5: floor quantizer with 0.25.
        do_reset();
        @(negedge clk); #1;
        step(20'h40000, 0);
        step(20'h40000, 0);
        step(20'h40000, 1);
        step(20'h40000, 0);
        @(negedge clk); #1;
        check(exp_q.size() == 0, "R2 all samples seen", exp_q.size(), 0);

        // R6 and R7: long runs with constant words.
        mean_run(20'h4CCCD, 65536);
        mean_run(20'hFFFFF, 16384);
        mean_run(20'h00001, 16384);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule